// File: doc/BRIEF.md
# Dual-Channel Disk I/O Window Decoder

This block turns the configuration state of a two-channel disk controller into the I/O map that the rest of the chip decodes against. Each channel has an 8-byte command window and a 1-byte control port. Each channel also has an 8-byte slice of a shared 16-byte bus-master window. A channel either sits at its fixed compatibility addresses or, when switched to native operation and base programming is unlocked, at addresses taken from its programmable base values. The block also reports whether the channel's interrupt is routed the native way or the compatibility way.

The map is held in registers, so it changes one clock after its configuration inputs change. The same registered map is used to classify incoming 16-bit I/O addresses. Each lookup reports whether the address hit, and if so the channel, the window kind and the byte offset within the window. A parameter `NUM_CH` builds the block with one or two channels. In a one-channel build the second channel and its bus-master slice do not exist.

Top module: `iowin_decoder`

## Requirements
- R1: Channel 0 takes its programmable bases only when its native bit `pif_native_i[0]` and `base_unlock_i` are both 1. Otherwise its command base is 0x01F0 and its control port is 0x03F6.
- R2: Channel 1 takes its programmable bases only when `pif_native_i[1]` and `base_unlock_i` are both 1. Otherwise its command base is 0x0170 and its control port is 0x0376.
- R3: A programmable command base equals the channel's raw command value with bits 2:0 forced to zero.
- R4: A programmable control port equals the channel's raw control value with bits 1:0 forced to zero, plus 2.
- R5: Channel 0 is enabled when `io_space_en_i` is 1. Channel 1 is enabled only when both `io_space_en_i` and `sec_chan_en_i` are 1, and never in a one-channel build.
- R6: The bus-master base is `bm_raw_i` with bits 3:0 forced to zero. Addresses base+0..7 belong to channel 0 and base+8..15 belong to channel 1. The bus-master window decodes whenever `io_space_en_i` is 1, whatever `sec_chan_en_i` is.
- R7: `irq_native_o[c]` is 1 exactly when `pif_native_i[c]` was 1 at the previous clock edge.
- R8: A hit reports its window kind on `hit_kind_o`: 0 means command, 1 means control, 2 means bus-master. `hit_offs_o` gives the address minus the window base. For a control hit the offset is 0. When there is no hit, `hit_chan_o`, `hit_kind_o` and `hit_offs_o` are all 0.
- R9: An address inside the command or control window of a disabled channel produces no hit.
- R10: When windows overlap, the hit goes to the first in this order: channel 0 command, channel 0 control, channel 1 command, channel 1 control, bus-master.
- R11: All map outputs show the configuration sampled at the previous clock edge. The hit outputs show the lookup presented at the previous edge, decoded against the map as it stood then. A cycle with `req_valid_i` low produces `hit_o` = 0.
- R12: While `rst` is high at a clock edge, every output register clears to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_space_en_i | input | 1 | I/O decode enable for the whole function |
| pif_native_i | input | NUM_CH | Per-channel native-operation select |
| base_unlock_i | input | 1 | Allows the programmable bases to take effect |
| sec_chan_en_i | input | 1 | Extra enable for channel 1 |
| cmd_raw_i | input | 16*NUM_CH | Raw programmable command base, channel c at bits 16c+15:16c |
| ctl_raw_i | input | 16*NUM_CH | Raw programmable control base, same packing |
| bm_raw_i | input | 16 | Raw bus-master base |
| req_valid_i | input | 1 | Lookup request strobe |
| req_addr_i | input | 16 | I/O address to classify |
| cmd_base_o | output | 16*NUM_CH | Active command base per channel |
| ctl_port_o | output | 16*NUM_CH | Active control port per channel |
| bm_base_o | output | 16 | Active bus-master base |
| chan_en_o | output | NUM_CH | Per-channel decode enable |
| irq_native_o | output | NUM_CH | Per-channel interrupt routing is native |
| hit_o | output | 1 | Lookup hit |
| hit_chan_o | output | 1 | Channel of the hit |
| hit_kind_o | output | 2 | Window kind of the hit |
| hit_offs_o | output | 3 | Byte offset within the window |

## Verification
Both kinds of result are due one clock edge after their stimulus. A configuration change applied between edges appears on the map outputs after the next edge. A lookup presented between edges appears on the hit outputs after the following edge. The driver changes inputs only on falling edges and stamps every expected lookup result with the cycle count at which it is due. The monitor compares on falling edges, and only once the cycle count has reached that stamp. The map checks are taken one falling edge after each configuration change, and lookups are issued only after the new map is in place.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    localparam int ADDR_W      = 16;
    localparam int CMD_OFF_W   = 3;
    localparam int BM_ALIGN_W  = 4;
    localparam int CTL_ALIGN_W = 2;
    localparam int CTL_ADJ     = 2;

    typedef logic [ADDR_W-1:0] ioaddr_t;

    typedef enum logic [1:0] {
        WIN_CMD = 2'd0,
        WIN_CTL = 2'd1,
        WIN_BM  = 2'd2
    } win_kind_e;

    typedef struct packed {
        ioaddr_t cmd_base;
        ioaddr_t ctl_port;
        logic    en;
        logic    irq_native;
    } chan_map_t;

    typedef struct packed {
        logic                 hit;
        logic                 chan;
        win_kind_e            kind;
        logic [CMD_OFF_W-1:0] offs;
    } hit_t;

    localparam ioaddr_t COMPAT_CMD0 = 16'h01F0;
    localparam ioaddr_t COMPAT_CTL0 = 16'h03F6;
    localparam ioaddr_t COMPAT_CMD1 = 16'h0170;
    localparam ioaddr_t COMPAT_CTL1 = 16'h0376;

    function automatic ioaddr_t compat_cmd(input int ch);
        return (ch == 0) ? COMPAT_CMD0 : COMPAT_CMD1;
    endfunction

    function automatic ioaddr_t compat_ctl(input int ch);
        return (ch == 0) ? COMPAT_CTL0 : COMPAT_CTL1;
    endfunction

    function automatic ioaddr_t prog_cmd(input ioaddr_t raw);
        return {raw[ADDR_W-1:CMD_OFF_W], {CMD_OFF_W{1'b0}}};
    endfunction

    function automatic ioaddr_t prog_ctl(input ioaddr_t raw);
        return {raw[ADDR_W-1:CTL_ALIGN_W], {CTL_ALIGN_W{1'b0}}} + ioaddr_t'(CTL_ADJ);
    endfunction

    function automatic ioaddr_t bm_align(input ioaddr_t raw);
        return {raw[ADDR_W-1:BM_ALIGN_W], {BM_ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/iowin_chan_sel.sv
module iowin_chan_sel
    import iowin_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic      native_i,
    input  logic      unlock_i,
    input  logic      decode_en_i,
    input  ioaddr_t   cmd_raw_i,
    input  ioaddr_t   ctl_raw_i,
    output chan_map_t map_o
);

    logic use_prog;

    always_comb begin
        use_prog         = native_i & unlock_i;
        map_o.cmd_base   = use_prog ? prog_cmd(cmd_raw_i) : compat_cmd(CH);
        map_o.ctl_port   = use_prog ? prog_ctl(ctl_raw_i) : compat_ctl(CH);
        map_o.en         = decode_en_i;
        map_o.irq_native = native_i;
    end

endmodule

// File: rtl/iowin_match.sv
module iowin_match
    import iowin_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  chan_map_t maps_i [NUM_CH],
    input  ioaddr_t   bm_base_i,
    input  logic      bm_en_i,
    input  logic      valid_i,
    input  ioaddr_t   addr_i,
    output hit_t      hit_o
);

    always_comb begin
        hit_o = '0;
        if (valid_i) begin
            // lowest priority first; later matches override
            if (bm_en_i && addr_i[ADDR_W-1:BM_ALIGN_W] == bm_base_i[ADDR_W-1:BM_ALIGN_W]) begin
                if (!addr_i[CMD_OFF_W] || NUM_CH > 1) begin
                    hit_o.hit  = 1'b1;
                    hit_o.chan = addr_i[CMD_OFF_W];
                    hit_o.kind = WIN_BM;
                    hit_o.offs = addr_i[CMD_OFF_W-1:0];
                end
            end
            for (int c = NUM_CH - 1; c >= 0; c--) begin
                if (maps_i[c].en && addr_i == maps_i[c].ctl_port) begin
                    hit_o.hit  = 1'b1;
                    hit_o.chan = 1'(c);
                    hit_o.kind = WIN_CTL;
                    hit_o.offs = '0;
                end
                if (maps_i[c].en &&
                    addr_i[ADDR_W-1:CMD_OFF_W] == maps_i[c].cmd_base[ADDR_W-1:CMD_OFF_W]) begin
                    hit_o.hit  = 1'b1;
                    hit_o.chan = 1'(c);
                    hit_o.kind = WIN_CMD;
                    hit_o.offs = addr_i[CMD_OFF_W-1:0];
                end
            end
        end
    end

    // R9
    always_comb begin
        if (hit_o.hit === 1'b1 && hit_o.kind != WIN_BM)
            chan_enabled_chk: assert (maps_i[hit_o.chan].en === 1'b1);
    end

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
    import iowin_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_space_en_i,
    input  logic [NUM_CH-1:0]   pif_native_i,
    input  logic                base_unlock_i,
    input  logic                sec_chan_en_i,
    input  logic [16*NUM_CH-1:0] cmd_raw_i,
    input  logic [16*NUM_CH-1:0] ctl_raw_i,
    input  logic [15:0]         bm_raw_i,
    input  logic                req_valid_i,
    input  logic [15:0]         req_addr_i,
    output logic [16*NUM_CH-1:0] cmd_base_o,
    output logic [16*NUM_CH-1:0] ctl_port_o,
    output logic [15:0]         bm_base_o,
    output logic [NUM_CH-1:0]   chan_en_o,
    output logic [NUM_CH-1:0]   irq_native_o,
    output logic                hit_o,
    output logic                hit_chan_o,
    output logic [1:0]          hit_kind_o,
    output logic [2:0]          hit_offs_o
);

    chan_map_t map_d [NUM_CH];
    chan_map_t map_q [NUM_CH];
    ioaddr_t   bm_base_q;
    logic      bm_en_q;
    hit_t      hit_d;
    hit_t      hit_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic dec_en;
        if (c == 0) begin : g_pri
            assign dec_en = io_space_en_i;
        end else begin : g_sec
            assign dec_en = io_space_en_i & sec_chan_en_i;
        end

        iowin_chan_sel #(.CH(c)) i_sel (
            .native_i    (pif_native_i[c]),
            .unlock_i    (base_unlock_i),
            .decode_en_i (dec_en),
            .cmd_raw_i   (cmd_raw_i[16*c +: 16]),
            .ctl_raw_i   (ctl_raw_i[16*c +: 16]),
            .map_o       (map_d[c])
        );

        always_ff @(posedge clk) begin
            if (rst) map_q[c] <= '0;
            else     map_q[c] <= map_d[c];
        end

        assign cmd_base_o[16*c +: 16] = map_q[c].cmd_base;
        assign ctl_port_o[16*c +: 16] = map_q[c].ctl_port;
        assign chan_en_o[c]           = map_q[c].en;
        assign irq_native_o[c]        = map_q[c].irq_native;

        // R3
        cmd_align_chk: assert property (@(posedge clk) disable iff (rst)
            cmd_base_o[16*c +: 3] == 3'b000);

        // R4
        ctl_adjust_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ctl_port_o[16*c +: 2] == 2'b10);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bm_base_q <= '0;
            bm_en_q   <= 1'b0;
        end else begin
            bm_base_q <= bm_align(bm_raw_i);
            bm_en_q   <= io_space_en_i;
        end
    end

    iowin_match #(.NUM_CH(NUM_CH)) i_match (
        .maps_i    (map_q),
        .bm_base_i (bm_base_q),
        .bm_en_i   (bm_en_q),
        .valid_i   (req_valid_i),
        .addr_i    (req_addr_i),
        .hit_o     (hit_d)
    );

    always_ff @(posedge clk) begin
        if (rst) hit_q <= '0;
        else     hit_q <= hit_d;
    end

    assign bm_base_o  = bm_base_q;
    assign hit_o      = hit_q.hit;
    assign hit_chan_o = hit_q.chan;
    assign hit_kind_o = hit_q.kind;
    assign hit_offs_o = hit_q.offs;

    // R6
    bm_align_chk: assert property (@(posedge clk) disable iff (rst)
        bm_base_o[3:0] == 4'h0);

    // R7
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_native_o == $past(pif_native_i));

    // R11
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && hit_o |-> $past(req_valid_i));

    // R8
    idle_fields_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (hit_kind_o == 2'd0 && hit_offs_o == 3'd0 && !hit_chan_o));

endmodule

// File: tb/test_iowin_decoder.sv
module test_iowin_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_en = 1'b0;
    logic [1:0]  pif = 2'b00;
    logic        unlock = 1'b0;
    logic        sec_en = 1'b0;
    logic [31:0] cmd_raw = '0;
    logic [31:0] ctl_raw = '0;
    logic [15:0] bm_raw = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;

    logic [31:0] cmd_base, ctl_port;
    logic [15:0] bm_base;
    logic [1:0]  chan_en, irq_native;
    logic        hit, hit_chan;
    logic [1:0]  hit_kind;
    logic [2:0]  hit_offs;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    iowin_decoder #(.NUM_CH(2)) i_iowin_decoder (
        .clk(clk), .rst(rst), .io_space_en_i(io_en), .pif_native_i(pif),
        .base_unlock_i(unlock), .sec_chan_en_i(sec_en),
        .cmd_raw_i(cmd_raw), .ctl_raw_i(ctl_raw), .bm_raw_i(bm_raw),
        .req_valid_i(req_valid), .req_addr_i(req_addr),
        .cmd_base_o(cmd_base), .ctl_port_o(ctl_port), .bm_base_o(bm_base),
        .chan_en_o(chan_en), .irq_native_o(irq_native),
        .hit_o(hit), .hit_chan_o(hit_chan), .hit_kind_o(hit_kind), .hit_offs_o(hit_offs)
    );

    typedef struct {
        int         due;
        logic       h;
        logic       ch;
        logic [1:0] kind;
        logic [2:0] off;
        string      req;
    } exp_t;

    exp_t sb[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // independent reference for the map
    function automatic logic [15:0] m_cmd(input int c);
        if (pif[c] && unlock) return {cmd_raw[16*c+3 +: 13], 3'b000};
        return (c == 0) ? 16'h01F0 : 16'h0170;
    endfunction

    function automatic logic [15:0] m_ctl(input int c);
        if (pif[c] && unlock) return {ctl_raw[16*c+2 +: 14], 2'b00} + 16'd2;
        return (c == 0) ? 16'h03F6 : 16'h0376;
    endfunction

    function automatic logic m_en(input int c);
        return (c == 0) ? io_en : (io_en & sec_en);
    endfunction

    task automatic lookup(input logic [15:0] a, input logic v, input string req);
        exp_t e;
        logic [15:0] bmb;
        e.due = cyc + 1; e.h = 0; e.ch = 0; e.kind = 0; e.off = 0; e.req = req;
        bmb = {bm_raw[15:4], 4'h0};
        if (v) begin
            if (io_en && a[15:4] == bmb[15:4]) begin
                e.h = 1; e.ch = a[3]; e.kind = 2; e.off = a[2:0];
            end
            for (int c = 1; c >= 0; c--) begin
                if (m_en(c) && a == m_ctl(c)) begin
                    e.h = 1; e.ch = 1'(c); e.kind = 1; e.off = 0;
                end
                if (m_en(c) && a >= m_cmd(c) && a < m_cmd(c) + 16'd8) begin
                    e.h = 1; e.ch = 1'(c); e.kind = 0; e.off = 3'(a - m_cmd(c));
                end
            end
        end
        req_addr  = a;
        req_valid = v;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check({e.req, " hit"},  32'(hit),      32'(e.h));
            check({e.req, " chan"}, 32'(hit_chan), 32'(e.ch));
            check({e.req, " kind"}, 32'(hit_kind), 32'(e.kind));
            check({e.req, " offs"}, 32'(hit_offs), 32'(e.off));
        end
    end

    task automatic check_map(input string req);
        for (int c = 0; c < 2; c++) begin
            check({req, " cmd base"}, 32'(cmd_base[16*c +: 16]), 32'(m_cmd(c)));
            check({req, " ctl port"}, 32'(ctl_port[16*c +: 16]), 32'(m_ctl(c)));
            check({req, " enable"},   32'(chan_en[c]),           32'(m_en(c)));
            check({req, " R7 irq"},   32'(irq_native[c]),        32'(pif[c]));
        end
        check({req, " R6 bm base"}, 32'(bm_base), 32'({bm_raw[15:4], 4'h0}));
    endtask

    task automatic settle;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        io_en = 1; pif = 2'b11; unlock = 1; sec_en = 1; bm_raw = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R12: reset holds everything at zero
        check("R12 cmd", cmd_base, 0);
        check("R12 ctl", ctl_port, 0);
        check("R12 misc", {bm_base, 4'b0, chan_en, irq_native, hit, hit_chan, hit_kind, hit_offs}, 0);
        io_en = 0; pif = 0; unlock = 0; sec_en = 0; bm_raw = 0;
        rst = 0;
        @(negedge clk);

        // R1 R2 R11: compatibility map
        io_en = 1; sec_en = 1; bm_raw = 16'hE00F;
        cmd_raw = {16'h9007, 16'hC0F7}; ctl_raw = {16'h9103, 16'hC0FB};
        @(negedge clk);
        check_map("R11 R1 R2 compat");
        lookup(16'h01F3, 1, "R8 R1 cmd0");
        lookup(16'h03F6, 1, "R8 R1 ctl0");
        lookup(16'h0177, 1, "R8 R2 cmd1");
        lookup(16'h0376, 1, "R2 ctl1");
        lookup(16'h01F8, 1, "R8 miss above cmd");
        lookup(16'h03F7, 1, "R8 miss ctl+1");
        lookup(16'h01F3, 0, "R11 no request");

        // R1 R2: native requested but locked
        pif = 2'b11;
        @(negedge clk);
        check_map("R1 R2 locked");
        lookup(16'hC0F2, 1, "R1 locked no prog");

        // R3 R4: unlocked programmable bases
        unlock = 1;
        @(negedge clk);
        check_map("R3 R4 prog");
        check("R3 cmd0", cmd_base[15:0], 16'hC0F0);
        check("R4 ctl0", ctl_port[15:0], 16'hC0FA);
        check("R3 cmd1", cmd_base[31:16], 16'h9000);
        check("R4 ctl1", ctl_port[31:16], 16'h9102);
        lookup(16'hC0F5, 1, "R3 cmd0 prog");
        lookup(16'hC0FA, 1, "R4 ctl0 prog");
        lookup(16'h9006, 1, "R3 cmd1 prog");
        lookup(16'h9102, 1, "R4 ctl1 prog");
        lookup(16'h01F0, 1, "R1 old compat gone");

        // R6: bus-master slices
        lookup(16'hE005, 1, "R6 bm ch0");
        lookup(16'hE00C, 1, "R6 bm ch1");
        lookup(16'hE010, 1, "R6 bm past end");

        // R5 R9: secondary disabled
        sec_en = 0;
        @(negedge clk);
        check_map("R5 sec off");
        lookup(16'h9001, 1, "R9 ch1 cmd disabled");
        lookup(16'h9102, 1, "R9 ch1 ctl disabled");
        lookup(16'hE009, 1, "R6 bm ch1 with sec off");

        // R10: channel 1 programmed onto channel 0 compat window
        sec_en = 1; pif = 2'b10; cmd_raw[31:16] = 16'h01F4; ctl_raw[31:16] = 16'h03F4;
        @(negedge clk);
        check_map("R10 overlap");
        lookup(16'h01F4, 1, "R10 cmd0 beats cmd1");
        lookup(16'h03F6, 1, "R10 ctl0 beats ctl1");
        bm_raw = 16'h01F0;
        @(negedge clk);
        lookup(16'h01F9, 1, "R10 bm loses to nothing");
        lookup(16'h01F2, 1, "R10 cmd beats bm");

        // R5 R9: whole function off
        io_en = 0;
        @(negedge clk);
        check_map("R5 all off");
        lookup(16'h01F2, 1, "R9 ch0 disabled");
        lookup(16'h01FA, 1, "R6 bm disabled");

        settle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule